// File: doc/BRIEF.md
# Sync-Word Gated Receive Byte Queue

This block sits behind a bit-slicing demodulator. It watches a serial stream of received bits, each one qualified by a one-cycle strobe, and waits for an 8-bit synchronisation byte that the host can program. Once that byte is seen and a fill-enable control input is high, the bits that follow are gathered into bytes, most significant bit first. Each byte is written into a four-entry queue.

The host talks to the block through 16-bit command words. Each word is presented with a one-cycle valid strobe. One command family replaces the sync byte. One fixed command pops the oldest queued byte into a read register, and a configuration input must allow that read. A complete search cycle always runs the same way: the host drops fill-enable, raises it again, waits for the sync byte, reads bytes, and drops fill-enable to end the frame. While fill-enable stays high after a match, the block never looks for the pattern a second time.

The block's flags report whether filling is active, whether the queue is empty or full, and whether a byte was lost because the queue was full.

Top module: `syncword_rx_fifo`

## Requirements
- R1: Asserting `rst_n` clears the block at once, and release takes effect synchronously. After reset the sync byte is 0xD4, `rd_data` is 0x00, `fill_active` and `overflow` are 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: A command whose upper byte is 0xCE loads its lower byte as the sync byte. Only the new value can then produce a match.
- R3: A search is armed only while `fill_en` is high. A match occurs when the last 8 strobed bits all arrived while armed and equal the sync byte, with the oldest bit compared to bit 7. `fill_active` rises on the clock edge of the matching strobe.
- R4: After a match, each group of 8 strobed bits is packed with the first bit in bit 7 and pushed as one byte. The matching bits themselves are not pushed.
- R5: Once `fill_en` is low, no further byte is pushed, starting from that same cycle. `fill_active` falls on the next edge, and any partly gathered byte is discarded.
- R6: After a match, the block does not search again while `fill_en` stays high, so a later copy of the sync byte is stored as data. A new search needs `fill_en` low and then high. Bits that arrive before the new search is armed take no part in it.
- R7: Command 0xB000 with `fifo_en` high loads the oldest queued byte into `rd_data` on the next edge. Bytes leave in the order they arrived.
- R8: Command 0xB000 with `fifo_en` low, and any command word other than 0xB000 or 0xCExx, leave `rd_data` and the queue unchanged.
- R9: A pop from an empty queue sets `rd_data` to 0x00 and keeps the queue empty.
- R10: The queue holds 4 bytes, and `fifo_full` is high when it holds 4. A push into a full queue is dropped and sets `overflow`. `overflow` stays set until the next time a search is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | One-cycle strobe qualifying `bit_in` |
| fill_en | input | 1 | Fill-enable control; a low-then-high transition restarts the search |
| fifo_en | input | 1 | Configuration bit that allows queue reads |
| cmd_vld | input | 1 | One-cycle strobe qualifying `cmd_word` |
| cmd_word | input | 16 | Host command word |
| rd_data | output | 8 | Byte returned by the last pop |
| fill_active | output | 1 | High between a match and the drop of `fill_en` |
| fifo_empty | output | 1 | Queue holds no byte |
| fifo_full | output | 1 | Queue holds 4 bytes |
| overflow | output | 1 | Sticky flag for a byte dropped on a full queue |

## Verification
The bench aims at the restart rule from several angles:
- It splits a sync byte across a drop and re-raise of `fill_en`. A hunter that keeps old bits in its window would falsely match on the second half.
- It sends the sync byte again as payload. A design that re-arms while `fill_en` stays high would swallow that byte instead of storing it.
- It drops `fill_en` in the middle of a byte. Any leftover bits would then corrupt the next frame's first byte.

At the queue boundaries, the bench pushes a fifth byte and then pops past empty. These steps catch a lost overflow flag, a pointer that wraps, and stale data returned on an empty pop. It also sends ignored commands, reads while `fifo_en` is low, and checks that a reset brings back the 0xD4 default.

// File: rtl/syncrx_pkg.sv
`timescale 1ns/1ps
package syncrx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FILL   = 2'd2
  } hunt_st_e;

  localparam logic [7:0]  OPC_SYNC_LOAD = 8'hCE;
  localparam logic [15:0] CMD_POP       = 16'hB000;
  localparam logic [7:0]  SYNC_DEFAULT  = 8'hD4;
endpackage

// File: rtl/syncrx_rst_sync.sv
`timescale 1ns/1ps
module syncrx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/syncrx_hunt.sv
`timescale 1ns/1ps
module syncrx_hunt
  import syncrx_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill_en,
  input  logic         bit_vld,
  input  logic         bit_in,
  input  logic [W-1:0] pattern,
  output logic         filling,
  output logic         rearm
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] SEEN_FULL = CW'(W);
  localparam logic [CW-1:0] SEEN_LAST = CW'(W - 1);

  hunt_st_e      st_q, st_d;
  logic [W-1:0]  win_q, win_d, win_next;
  logic [CW-1:0] seen_q, seen_d;
  logic          win_en;

  assign win_next = {win_q[W-2:0], bit_in};

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    win_d  = win_q;
    win_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        seen_d = '0;
        if (fill_en) st_d = ST_SEARCH;
      end
      ST_SEARCH: begin
        if (!fill_en) begin
          st_d   = ST_IDLE;
          seen_d = '0;
        end else if (bit_vld) begin
          win_en = 1'b1;
          win_d  = win_next;
          if (seen_q != SEEN_FULL) seen_d = seen_q + 1'b1;
          if ((seen_q >= SEEN_LAST) && (win_next == pattern)) st_d = ST_FILL;
        end
      end
      ST_FILL: begin
        seen_d = '0;
        if (!fill_en) st_d = ST_IDLE;
      end
      default: begin
        st_d   = ST_IDLE;
        seen_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      seen_q <= '0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  assign filling = (st_q == ST_FILL);
  assign rearm   = (st_q == ST_IDLE) && fill_en;
endmodule

// File: rtl/syncrx_packer.sv
`timescale 1ns/1ps
module syncrx_packer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         bit_vld,
  input  logic         bit_in,
  output logic         push,
  output logic [W-1:0] push_data
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  logic [W-2:0]  acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc_en;

  always_comb begin
    acc_en = active && bit_vld;
    acc_d  = {acc_q[W-3:0], bit_in};
    if (!active)     cnt_d = '0;
    else if (bit_vld) cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign push      = active && bit_vld && (cnt_q == CNT_LAST);
  assign push_data = {acc_q, bit_in};
endmodule

// File: rtl/syncrx_fifo.sv
`timescale 1ns/1ps
module syncrx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4   // power of two
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  input  logic         ovf_clr,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         overflow
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0] we;
  logic [AW:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [W-1:0] rdata_q, rdata_d;
  logic         ovf_q, ovf_d;
  logic         push_ok, pop_ok;

  assign empty   = (wptr_q == rptr_q);
  assign full    = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign we[i] = push_ok && (wptr_q[AW-1:0] == AW'(i));
  end

  always_comb begin
    wptr_d  = push_ok ? wptr_q + 1'b1 : wptr_q;
    rptr_d  = pop_ok  ? rptr_q + 1'b1 : rptr_q;
    rdata_d = rdata_q;
    if (pop) rdata_d = empty ? '0 : mem_q[rptr_q[AW-1:0]];
    ovf_d = ovf_q;
    if (ovf_clr)          ovf_d = 1'b0;
    else if (push && full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we[i]) mem_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (pop) rdata_q <= rdata_d;
  end

  assign rdata    = rdata_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/syncword_rx_fifo.sv
`timescale 1ns/1ps
module syncword_rx_fifo
  import syncrx_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CMD_W  = 16,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  input  logic              bit_vld,
  input  logic              fill_en,
  input  logic              fifo_en,
  input  logic              cmd_vld,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [BYTE_W-1:0] rd_data,
  output logic              fill_active,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              overflow
);
  localparam int unsigned OPC_W = CMD_W - BYTE_W;

  logic              rst_sn;
  logic [BYTE_W-1:0] pat_q, pat_d;
  logic              pat_ld, pop_req;
  logic              filling, rearm;
  logic              push;
  logic [BYTE_W-1:0] push_data;

  syncrx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  // command decode
  always_comb begin
    pat_ld  = cmd_vld && (cmd_word[CMD_W-1:BYTE_W] == OPC_W'(OPC_SYNC_LOAD));
    pop_req = cmd_vld && fifo_en && (cmd_word == CMD_W'(CMD_POP));
    pat_d   = pat_ld ? cmd_word[BYTE_W-1:0] : pat_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) pat_q <= BYTE_W'(SYNC_DEFAULT);
    else         pat_q <= pat_d;
  end

  syncrx_hunt #(.W(BYTE_W)) u_hunt (
    .clk(clk), .rst_n(rst_sn), .fill_en(fill_en), .bit_vld(bit_vld),
    .bit_in(bit_in), .pattern(pat_q), .filling(filling), .rearm(rearm)
  );

  syncrx_packer #(.W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_sn), .active(filling && fill_en), .bit_vld(bit_vld),
    .bit_in(bit_in), .push(push), .push_data(push_data)
  );

  syncrx_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sn), .push(push), .wdata(push_data), .pop(pop_req),
    .ovf_clr(rearm), .rdata(rd_data), .empty(fifo_empty), .full(fifo_full),
    .overflow(overflow)
  );

  assign fill_active = filling;
endmodule

// File: rtl/syncword_rx_fifo_chk.sv
`timescale 1ns/1ps
module syncword_rx_fifo_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fill_en,
  input logic        bit_vld,
  input logic        fifo_en,
  input logic        cmd_vld,
  input logic [15:0] cmd_word,
  input logic [7:0]  rd_data,
  input logic        fill_active,
  input logic        fifo_empty,
  input logic        fifo_full,
  input logic        overflow
);
  logic pop_cmd;
  assign pop_cmd = cmd_vld && fifo_en && (cmd_word == 16'hB000);

  p_fill_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_active |-> $past(fill_en));

  p_fill_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_active) |-> $past(bit_vld));

  p_push_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_empty) |-> $past(fill_en) && $past(fill_active));

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_cmd |=> $stable(rd_data));

  p_pop_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_cmd && fifo_empty) |=> (rd_data == 8'h00));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && fill_active) |=> overflow);
endmodule

bind syncword_rx_fifo syncword_rx_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .fill_en(fill_en), .bit_vld(bit_vld),
  .fifo_en(fifo_en), .cmd_vld(cmd_vld), .cmd_word(cmd_word), .rd_data(rd_data),
  .fill_active(fill_active), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
  .overflow(overflow)
);

// File: tb/syncword_rx_fifo_bench.sv
`timescale 1ns/1ps
module syncword_rx_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0, bit_vld = 1'b0, fill_en = 1'b0, fifo_en = 1'b1;
  logic        cmd_vld = 1'b0;
  logic [15:0] cmd_word = 16'h0;
  logic [7:0]  rd_data;
  logic        fill_active, fifo_empty, fifo_full, overflow;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  syncword_rx_fifo u_syncword_rx_fifo (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .fill_en(fill_en), .fifo_en(fifo_en), .cmd_vld(cmd_vld), .cmd_word(cmd_word),
    .rd_data(rd_data), .fill_active(fill_active), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .overflow(overflow)
  );

  // vector: {op[2:0], req[3:0], arg[15:0], exp[7:0]}
  // flags exp[3:0] = {fill_active, fifo_empty, fifo_full, overflow}
  localparam logic [2:0] V_FL = 3'd0, V_POP = 3'd1, V_EN = 3'd2, V_BY = 3'd3, V_CMD = 3'd4;
  localparam int NV = 38;
  localparam logic [30:0] VEC [NV] = '{
    {V_FL,  4'd1,  16'h0000, 8'h04},  // R1 reset flags
    {V_POP, 4'd9,  16'h0000, 8'h00},  // R9 empty pop
    {V_EN,  4'd3,  16'h0001, 8'h00},  // R3 arm
    {V_BY,  4'd3,  16'h00D4, 8'h00},  // R3 default sync byte
    {V_FL,  4'd3,  16'h0000, 8'h0C},  // R3 filling, empty
    {V_BY,  4'd4,  16'h005A, 8'h00},  // R4 payload
    {V_BY,  4'd6,  16'h00D4, 8'h00},  // R6 sync value as data
    {V_FL,  4'd4,  16'h0000, 8'h08},
    {V_POP, 4'd7,  16'h0000, 8'h5A},  // R7 order
    {V_POP, 4'd6,  16'h0000, 8'hD4},  // R6 stored as data
    {V_FL,  4'd7,  16'h0000, 8'h0C},
    {V_EN,  4'd5,  16'h0000, 8'h00},  // R5 drop fill_en
    {V_FL,  4'd5,  16'h0000, 8'h04},
    {V_BY,  4'd5,  16'h0033, 8'h00},
    {V_FL,  4'd5,  16'h0000, 8'h04},  // R5 nothing pushed
    {V_CMD, 4'd2,  16'hCE3C, 8'h00},  // R2 new sync byte
    {V_EN,  4'd2,  16'h0001, 8'h00},
    {V_BY,  4'd2,  16'h00D4, 8'h00},
    {V_FL,  4'd2,  16'h0000, 8'h04},  // R2 old value no match
    {V_BY,  4'd2,  16'h003C, 8'h00},
    {V_FL,  4'd2,  16'h0000, 8'h0C},  // R2 new value matches
    {V_BY,  4'd10, 16'h0011, 8'h00},
    {V_BY,  4'd10, 16'h0022, 8'h00},
    {V_BY,  4'd10, 16'h0033, 8'h00},
    {V_BY,  4'd10, 16'h0044, 8'h00},
    {V_FL,  4'd10, 16'h0000, 8'h0A},  // R10 full
    {V_BY,  4'd10, 16'h0055, 8'h00},
    {V_FL,  4'd10, 16'h0000, 8'h0B},  // R10 overflow
    {V_POP, 4'd10, 16'h0000, 8'h11},
    {V_POP, 4'd10, 16'h0000, 8'h22},
    {V_POP, 4'd10, 16'h0000, 8'h33},
    {V_POP, 4'd10, 16'h0000, 8'h44},  // R10 fifth byte dropped
    {V_POP, 4'd9,  16'h0000, 8'h00},  // R9
    {V_FL,  4'd10, 16'h0000, 8'h0D},  // R10 sticky
    {V_EN,  4'd6,  16'h0000, 8'h00},
    {V_FL,  4'd10, 16'h0000, 8'h05},
    {V_EN,  4'd6,  16'h0001, 8'h00},
    {V_FL,  4'd10, 16'h0000, 8'h04}   // R10 cleared on rearm
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    bit_in = b; bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic set_fill(input logic v);
    fill_en = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic issue(input logic [15:0] w);
    cmd_word = w; cmd_vld = 1'b1;
    @(negedge clk);
    cmd_vld = 1'b0; cmd_word = 16'h0;
  endtask

  function automatic logic [3:0] flags();
    return {fill_active, fifo_empty, fifo_full, overflow};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(1, {24'h0, rd_data}, 32'h00, "rd_data after reset");

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      case (v[30:28])
        V_FL:  check(int'(v[27:24]), {28'h0, flags()}, {28'h0, v[3:0]}, "flags");
        V_POP: begin
          issue(16'hB000);
          check(int'(v[27:24]), {24'h0, rd_data}, {24'h0, v[7:0]}, "pop data");
        end
        V_EN:  set_fill(v[8]);
        V_BY:  send_byte(v[15:8]);
        default: issue(v[23:8]);
      endcase
    end

    // R6: bits before a rearm take no part in the new search (pattern 0x3C)
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    set_fill(1'b0); set_fill(1'b1);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
    check(6, {31'h0, fill_active}, 32'h0, "split sync across rearm");
    send_byte(8'h3C);
    check(3, {31'h0, fill_active}, 32'h1, "match after rearm");

    // R8: read gated by fifo_en, unknown command ignored
    send_byte(8'h77);
    fifo_en = 1'b0;
    issue(16'hB000);
    check(8, {24'h0, rd_data}, 32'h00, "pop with fifo_en low");
    check(8, {31'h0, fifo_empty}, 32'h0, "queue kept with fifo_en low");
    fifo_en = 1'b1;
    issue(16'hB001);
    check(8, {24'h0, rd_data}, 32'h00, "other command ignored");
    check(8, {31'h0, fifo_empty}, 32'h0, "queue kept on other command");
    issue(16'hB000);
    check(7, {24'h0, rd_data}, 32'h77, "pop after gating");

    // R5: partial byte discarded when fill_en drops
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    set_fill(1'b0);
    check(5, {31'h0, fifo_empty}, 32'h1, "partial byte not pushed");
    set_fill(1'b1);
    send_byte(8'h3C);
    send_byte(8'h0F);
    issue(16'hB000);
    check(4, {24'h0, rd_data}, 32'h0F, "fresh byte after partial drop");

    // R1: asynchronous reset mid-frame, default sync byte restored
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(1, {28'h0, flags()}, 32'h4, "flags during reset");
    check(1, {24'h0, rd_data}, 32'h00, "rd_data during reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    set_fill(1'b0); set_fill(1'b1);
    send_byte(8'h3C);
    check(1, {31'h0, fill_active}, 32'h0, "old pattern forgotten");
    send_byte(8'hD4);
    check(1, {31'h0, fill_active}, 32'h1, "default pattern matches");

    finish_run();
  end
endmodule